// File: doc/BRIEF.md
# Coherent Byte-Access Timer Channel Value Register

This block holds the 16-bit value of one timer channel and lets an 8-bit register bus reach it as two bytes. In capture mode the register takes the free-running counter value whenever the capture-load strobe fires. In compare/PWM mode it holds the match value, which is driven out on a 16-bit compare output for the match and PWM logic elsewhere in the timer.

Because the bus moves one byte at a time, the block keeps a 16-bit transfer coherent in both directions. In capture mode, the first byte read of a pair freezes the whole value into a read buffer, so a capture that lands between the two reads cannot tear the pair. In compare/PWM mode, byte writes collect in a write buffer, and the active value changes in a single step only once both bytes are present, whichever byte came first. A write to the channel's status/control register throws away any half-finished read or write pair.

The byte count, bus width and base address are parameters. The most significant byte sits at the base address, and lower-order bytes follow at rising addresses.

Top module: `chan_value_reg`

## Requirements
- R1: On a synchronous active-low reset the live value, both buffers and both latch states clear. Afterwards `cmp_value` reads 0, bus reads return 0, and a lone byte write made before the reset cannot later complete a pair.
- R2: The high byte (bits 15..8) is at `BASE_ADDR` and the low byte (bits 7..0) is at `BASE_ADDR+1`. A read of any other address returns 0. A write to any other address changes no value and arms no latch.
- R3: In capture mode a `cap_load` pulse loads `cap_value` into the live register at that clock edge. In compare mode `cap_load` is ignored.
- R4: In capture mode the first byte read of a pair, high or low, freezes all 16 bits. The partner read returns the frozen byte even if a capture happened in between.
- R5: Reading the partner byte releases the read latch, so the next read pair returns the newest captured value. Captures made while the latch is frozen still update the live register.
- R6: In compare mode a single byte write leaves `cmp_value` unchanged. Once both bytes have been written, the new 16-bit value appears on `cmp_value` one clock edge after the edge that accepted the second byte.
- R7: A high-then-low write pair and a low-then-high write pair give the same result.
- R8: Writing the same byte twice before its partner replaces the buffered byte and does not complete the pair.
- R9: A `ctl_wr` pulse discards a half-finished write pair and releases a frozen read latch. The next byte access starts a new pair.
- R10: `cmp_value` is 0 while `capture_mode` is 1. Bus writes made in capture mode are ignored, and leaving a mode drops any half-finished pair.
- R11: In compare mode a bus read returns the byte of the active value directly, with no freezing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register bus byte address |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | BUS_W (8) | Write data byte |
| bus_rdata | output | BUS_W (8) | Read data byte, combinational while `bus_rd` is high |
| capture_mode | input | 1 | 1 selects capture, 0 selects compare/PWM |
| cap_load | input | 1 | Capture strobe from the edge logic |
| cap_value | input | NB*BUS_W (16) | Counter value to capture |
| ctl_wr | input | 1 | Write strobe of the channel status/control register |
| cmp_value | output | NB*BUS_W (16) | Active match value, 0 in capture mode |

## Verification
The embedded assertions watch, on every cycle, the update rules of the live register: it loads exactly the captured value, it loads exactly the write buffer on a transfer, and it otherwise holds. They also check that a frozen read buffer never moves, that a control write leaves both latches idle, and that a single byte write never starts a transfer. Only the bench's scenarios can show the end-to-end coherency properties. These include a capture landing between the two reads of a pair, the equivalence of the two write orders, and a repeated byte write. They also include a control write in the middle of a read pair and of a write pair, accesses to unmapped addresses, and the exact cycle on which a completed write pair reaches the compare output.

// File: rtl/chan_value_pkg.sv
// Package: shared types for the channel value register.
// Assumes: nothing beyond the standard; it holds only the mode encoding.
package chan_value_pkg;
    // Channel operating mode as seen by the value register.
    typedef enum logic {
        CV_COMPARE = 1'b0,
        CV_CAPTURE = 1'b1
    } cv_mode_e;
endpackage

// File: rtl/chan_value_decode.sv
// Module: chan_value_decode
// Maps a bus byte address onto a one-hot byte-lane select. Lane 0 holds
// the least significant byte. The most significant lane sits at BASE_ADDR
// and lower lanes follow at increasing addresses.
// Assumes: BASE_ADDR + NB - 1 does not wrap the address space.
module chan_value_decode #(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        NB        = 2,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NB-1:0]     lane_hit
);
    // One comparator per lane; offset k selects lane NB-1-k.
    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(k);
        assign lane_hit[NB-1-k] = (addr == LANE_ADDR);
    end
endmodule

// File: rtl/chan_value_rdlat.sv
// Module: chan_value_rdlat
// Read coherency latch. In capture mode the first lane read of a group
// snapshots the full live value. Later reads return the snapshot until
// every lane has been read, which releases it. The control strobe and
// leaving capture mode release it at once.
// Assumes: rd_hit is one-hot or zero and is already qualified by the read
// strobe.
module chan_value_rdlat #(
    parameter int unsigned NB    = 2,
    parameter int unsigned BUS_W = 8,
    localparam int unsigned DW   = NB * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             clear,
    input  logic [NB-1:0]    rd_hit,
    input  logic [DW-1:0]    live,
    output logic [BUS_W-1:0] rdata
);
    logic          locked_q;
    logic [NB-1:0] seen_q;
    logic [DW-1:0] frozen_q;
    logic [NB-1:0] seen_nx;
    logic [DW-1:0] src;

    // Lanes read so far, including the one being read now.
    assign seen_nx = (locked_q ? seen_q : '0) | rd_hit;

    // Tracks the freeze/release state of the read group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            seen_q   <= '0;
            frozen_q <= '0;
        end else if (clear || !cap_en) begin
            locked_q <= 1'b0;
            seen_q   <= '0;
        end else if (|rd_hit) begin
            if (&seen_nx) begin
                locked_q <= 1'b0;
                seen_q   <= '0;
            end else begin
                if (!locked_q) begin
                    frozen_q <= live;
                end
                locked_q <= 1'b1;
                seen_q   <= seen_nx;
            end
        end
    end

    // Selects the snapshot while frozen, otherwise the live value.
    assign src = (cap_en && locked_q) ? frozen_q : live;

    // Drives the byte of the selected lane, zero when no lane is read.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NB; k++) begin
            if (rd_hit[k]) begin
                rdata = src[k*BUS_W +: BUS_W];
            end
        end
    end

    // R4: a frozen snapshot does not move while the group is open.
    p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(frozen_q));

    // R9: a control write leaves the read group idle.
    p_ctl_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!locked_q && seen_q == '0));
endmodule

// File: rtl/chan_value_wrlat.sv
// Module: chan_value_wrlat
// Write coherency latch. Each lane write lands in its own buffer byte and
// marks that lane pending. The write that completes the set raises a
// one-cycle transfer request and clears every pending mark.
// Assumes: wr_hit is one-hot or zero and is already qualified by the write
// strobe; the consumer loads wbuf in the cycle xfer is high.
module chan_value_wrlat #(
    parameter int unsigned NB    = 2,
    parameter int unsigned BUS_W = 8,
    localparam int unsigned DW   = NB * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic             clear,
    input  logic [NB-1:0]    wr_hit,
    input  logic [BUS_W-1:0] wdata,
    output logic [DW-1:0]    wbuf,
    output logic             xfer
);
    logic [NB-1:0]    pend_q;
    logic             xfer_q;
    logic [BUS_W-1:0] lane_q [NB];
    logic [NB-1:0]    pend_nx;

    // Pending lanes including the one being written now.
    assign pend_nx = pend_q | wr_hit;

    // Tracks pending lanes and raises the transfer request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            xfer_q <= 1'b0;
        end else if (clear || !cmp_en) begin
            pend_q <= '0;
            xfer_q <= 1'b0;
        end else begin
            xfer_q <= 1'b0;
            if (|wr_hit) begin
                if (&pend_nx) begin
                    pend_q <= '0;
                    xfer_q <= 1'b1;
                end else begin
                    pend_q <= pend_nx;
                end
            end
        end
    end

    // One buffer byte per lane; a repeat write simply overwrites it.
    for (genvar g = 0; g < NB; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (cmp_en && !clear && wr_hit[g]) begin
                lane_q[g] <= wdata;
            end
        end
        assign wbuf[g*BUS_W +: BUS_W] = lane_q[g];
    end

    assign xfer = xfer_q;

    // R9: a control write discards every pending lane.
    p_ctl_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pend_q == '0 && !xfer_q));

    // R8: from an empty set, one lane write cannot request a transfer.
    p_single_no_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0 && $onehot0(wr_hit) && NB > 1) |=> !xfer_q);
endmodule

// File: rtl/chan_value_reg.sv
// Module: chan_value_reg (top)
// Timer channel value register with byte-wide bus access. It holds the
// live 16-bit value, which is loaded by captures in capture mode and by
// coherent write pairs in compare mode. Reads go through the read latch
// and writes through the write latch.
// Assumes: one bus strobe per cycle; capture_mode is static around a pair.
module chan_value_reg
    import chan_value_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        BUS_W     = 8,
    parameter int unsigned        NB        = 2,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h20,
    localparam int unsigned       DW        = NB * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              capture_mode,
    input  logic              cap_load,
    input  logic [DW-1:0]     cap_value,
    input  logic              ctl_wr,
    output logic [DW-1:0]     cmp_value
);
    cv_mode_e      mode;
    logic          cap_en;
    logic          cmp_en;
    logic [NB-1:0] lane_hit;
    logic [NB-1:0] rd_hit;
    logic [NB-1:0] wr_hit;
    logic [DW-1:0] live_q;
    logic [DW-1:0] wbuf;
    logic          xfer;

    assign mode   = cv_mode_e'(capture_mode);
    assign cap_en = (mode == CV_CAPTURE);
    assign cmp_en = (mode == CV_COMPARE);
    assign rd_hit = lane_hit & {NB{bus_rd}};
    assign wr_hit = lane_hit & {NB{bus_wr}};

    chan_value_decode #(
        .ADDR_W    (ADDR_W),
        .NB        (NB),
        .BASE_ADDR (BASE_ADDR)
    ) decode_i (
        .addr     (bus_addr),
        .lane_hit (lane_hit)
    );

    chan_value_rdlat #(
        .NB    (NB),
        .BUS_W (BUS_W)
    ) rdlat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .clear  (ctl_wr),
        .rd_hit (rd_hit),
        .live   (live_q),
        .rdata  (bus_rdata)
    );

    chan_value_wrlat #(
        .NB    (NB),
        .BUS_W (BUS_W)
    ) wrlat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_en (cmp_en),
        .clear  (ctl_wr),
        .wr_hit (wr_hit),
        .wdata  (bus_wdata),
        .wbuf   (wbuf),
        .xfer   (xfer)
    );

    // Live value: captures in capture mode, coherent transfers in compare mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (cap_en && cap_load) begin
            live_q <= cap_value;
        end else if (cmp_en && xfer) begin
            live_q <= wbuf;
        end
    end

    // The match value is only presented in compare mode.
    assign cmp_value = cmp_en ? live_q : '0;

    // R3: a capture in capture mode loads exactly the counter value.
    p_capture_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_mode && cap_load) |=> (live_q == $past(cap_value)));

    // R6: a transfer request loads exactly the assembled buffer.
    p_xfer_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !capture_mode) |=> (live_q == $past(wbuf)));

    // R10: without a capture or transfer the live value holds.
    p_live_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(capture_mode && cap_load) && !(xfer && !capture_mode)) |=> $stable(live_q));
endmodule

// File: tb/chan_value_reg_tb_top.sv
// Bench: vector table walked by one loop, then directed reset tests.
module chan_value_reg_tb_top;
    localparam logic [7:0] BASE = 8'h20;

    localparam logic [3:0] OP_IDLE = 4'd0; // check cmp_value against exp
    localparam logic [3:0] OP_MODE = 4'd1; // capture_mode <= data[0]
    localparam logic [3:0] OP_CAP  = 4'd2; // capture data
    localparam logic [3:0] OP_WRH  = 4'd3; // write high byte data[7:0]
    localparam logic [3:0] OP_WRL  = 4'd4; // write low byte
    localparam logic [3:0] OP_RDH  = 4'd5; // read high byte, expect exp[7:0]
    localparam logic [3:0] OP_RDL  = 4'd6; // read low byte
    localparam logic [3:0] OP_CTL  = 4'd7; // control register write
    localparam logic [3:0] OP_RDX  = 4'd8; // read unmapped BASE+2
    localparam logic [3:0] OP_WRX  = 4'd9; // write unmapped BASE+2

    // {op, requirement number, data, expected}
    localparam int NV = 56;
    localparam logic [39:0] VEC [NV] = '{
        {OP_MODE, 4'd0,  16'h0000, 16'h0000},
        {OP_IDLE, 4'd1,  16'h0000, 16'h0000}, // R1
        {OP_WRH,  4'd0,  16'h0012, 16'h0000},
        {OP_IDLE, 4'd6,  16'h0000, 16'h0000}, // R6 one byte only
        {OP_WRL,  4'd0,  16'h0034, 16'h0000},
        {OP_IDLE, 4'd6,  16'h0000, 16'h0000}, // R6 not yet
        {OP_IDLE, 4'd6,  16'h0000, 16'h1234}, // R6 now
        {OP_RDH,  4'd11, 16'h0000, 16'h0012}, // R11
        {OP_RDL,  4'd11, 16'h0000, 16'h0034}, // R11
        {OP_WRL,  4'd0,  16'h00CD, 16'h0000},
        {OP_WRH,  4'd0,  16'h00AB, 16'h0000},
        {OP_IDLE, 4'd7,  16'h0000, 16'h1234}, // R7
        {OP_IDLE, 4'd7,  16'h0000, 16'hABCD}, // R7
        {OP_WRH,  4'd0,  16'h0011, 16'h0000},
        {OP_WRH,  4'd0,  16'h0022, 16'h0000},
        {OP_IDLE, 4'd8,  16'h0000, 16'hABCD}, // R8
        {OP_IDLE, 4'd8,  16'h0000, 16'hABCD}, // R8
        {OP_WRL,  4'd0,  16'h0033, 16'h0000},
        {OP_IDLE, 4'd8,  16'h0000, 16'hABCD}, // R8
        {OP_IDLE, 4'd8,  16'h0000, 16'h2233}, // R8
        {OP_WRH,  4'd0,  16'h0055, 16'h0000},
        {OP_CTL,  4'd0,  16'h0000, 16'h0000},
        {OP_WRL,  4'd0,  16'h0066, 16'h0000},
        {OP_IDLE, 4'd9,  16'h0000, 16'h2233}, // R9
        {OP_IDLE, 4'd9,  16'h0000, 16'h2233}, // R9
        {OP_WRH,  4'd0,  16'h0077, 16'h0000},
        {OP_IDLE, 4'd9,  16'h0000, 16'h2233}, // R9
        {OP_IDLE, 4'd9,  16'h0000, 16'h7766}, // R9
        {OP_MODE, 4'd0,  16'h0001, 16'h0000},
        {OP_IDLE, 4'd10, 16'h0000, 16'h0000}, // R10
        {OP_WRH,  4'd0,  16'h0099, 16'h0000},
        {OP_WRL,  4'd0,  16'h0088, 16'h0000},
        {OP_RDH,  4'd10, 16'h0000, 16'h0077}, // R10
        {OP_RDL,  4'd10, 16'h0000, 16'h0066}, // R10
        {OP_CAP,  4'd0,  16'h1357, 16'h0000},
        {OP_RDH,  4'd3,  16'h0000, 16'h0013}, // R3
        {OP_CAP,  4'd0,  16'h2468, 16'h0000},
        {OP_RDL,  4'd4,  16'h0000, 16'h0057}, // R4
        {OP_RDH,  4'd5,  16'h0000, 16'h0024}, // R5
        {OP_RDL,  4'd5,  16'h0000, 16'h0068}, // R5
        {OP_RDL,  4'd4,  16'h0000, 16'h0068}, // R4
        {OP_CAP,  4'd0,  16'hAAAA, 16'h0000},
        {OP_RDH,  4'd4,  16'h0000, 16'h0024}, // R4
        {OP_RDH,  4'd5,  16'h0000, 16'h00AA}, // R5
        {OP_CAP,  4'd0,  16'hBEEF, 16'h0000},
        {OP_CTL,  4'd0,  16'h0000, 16'h0000},
        {OP_RDL,  4'd9,  16'h0000, 16'h00EF}, // R9
        {OP_RDH,  4'd9,  16'h0000, 16'h00BE}, // R9
        {OP_MODE, 4'd0,  16'h0000, 16'h0000},
        {OP_CAP,  4'd0,  16'h0F0F, 16'h0000},
        {OP_IDLE, 4'd3,  16'h0000, 16'hBEEF}, // R3
        {OP_RDX,  4'd2,  16'h0000, 16'h0000}, // R2
        {OP_WRX,  4'd0,  16'h00FF, 16'h0000},
        {OP_WRH,  4'd0,  16'h0001, 16'h0000},
        {OP_IDLE, 4'd2,  16'h0000, 16'hBEEF}, // R2
        {OP_IDLE, 4'd2,  16'h0000, 16'hBEEF}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        capture_mode = 1'b0;
    logic        cap_load = 1'b0;
    logic [15:0] cap_value = '0;
    logic        ctl_wr = 1'b0;
    logic [15:0] cmp_value;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chan_value_reg #(.BASE_ADDR(BASE)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .capture_mode (capture_mode),
        .cap_load     (cap_load),
        .cap_value    (cap_value),
        .ctl_wr       (ctl_wr),
        .cmp_value    (cmp_value)
    );

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drives one vector at a falling edge; checks sample 2 ns later.
    task automatic apply(input logic [39:0] v);
        logic [3:0]  op;
        logic [15:0] dat;
        logic [15:0] exp;
        int          req;
        op  = v[39:36];
        req = int'(v[35:32]);
        dat = v[31:16];
        exp = v[15:0];
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; cap_load = 1'b0; ctl_wr = 1'b0;
        case (op)
            OP_MODE: capture_mode = dat[0];
            OP_CAP:  begin cap_load = 1'b1; cap_value = dat; end
            OP_WRH:  begin bus_wr = 1'b1; bus_addr = BASE; bus_wdata = dat[7:0]; end
            OP_WRL:  begin bus_wr = 1'b1; bus_addr = BASE + 8'd1; bus_wdata = dat[7:0]; end
            OP_WRX:  begin bus_wr = 1'b1; bus_addr = BASE + 8'd2; bus_wdata = dat[7:0]; end
            OP_RDH:  begin bus_rd = 1'b1; bus_addr = BASE; end
            OP_RDL:  begin bus_rd = 1'b1; bus_addr = BASE + 8'd1; end
            OP_RDX:  begin bus_rd = 1'b1; bus_addr = BASE + 8'd2; end
            OP_CTL:  ctl_wr = 1'b1;
            default: ;
        endcase
        #2;
        if (op == OP_IDLE) check(req, "cmp_value", cmp_value, exp);
        if (op == OP_RDH || op == OP_RDL || op == OP_RDX)
            check(req, "bus_rdata", {8'h00, bus_rdata}, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state at the ports
        check(1, "cmp_value after reset", cmp_value, 16'h0000);
        bus_rd = 1'b1; bus_addr = BASE; #1;
        check(1, "high byte after reset", {8'h00, bus_rdata}, 16'h0000);
        bus_rd = 1'b0;

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R1: a reset mid-pair drops the pending byte and clears the value
        apply({OP_WRH, 4'd0, 16'h005A, 16'h0000});
        @(negedge clk);
        bus_wr = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; #2;
        check(1, "cmp_value after mid-test reset", cmp_value, 16'h0000);
        apply({OP_WRL, 4'd0, 16'h0011, 16'h0000});
        apply({OP_IDLE, 4'd1, 16'h0000, 16'h0000});
        apply({OP_IDLE, 4'd1, 16'h0000, 16'h0000});
        apply({OP_WRH, 4'd0, 16'h0022, 16'h0000});
        apply({OP_IDLE, 4'd1, 16'h0000, 16'h0000});
        apply({OP_IDLE, 4'd7, 16'h0000, 16'h2211});

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R0 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule